// File: doc/BRIEF.md
# Parallel Host-Bus Interface Controller

This block turns single requests from an internal request/response port into accesses on a simple external parallel bus with one chip select. Each access latches the address with a one-cycle address strobe, then holds a read or a write strobe for a fixed number of cycles. The polarity of each of the three strobes can be programmed. A requester presents a request and holds it until the controller answers with a one-cycle ready pulse. Read data comes back with that pulse.

A control register sits at a single register-port address. Two enables let external FIFO flags hold off accesses: a full flag can hold off writes, and an empty flag can hold off reads. A self-clearing command bit makes the next bus access a write of a stored configuration word to an attached pseudo-static RAM. That write is marked by a dedicated configuration-enable output.

Top module: `hbus_ctrl`

## Requirements
- R1: After reset, the control register reads 0x0000_0010. The address-strobe polarity is 1 and every other field is 0. The chip select is high, the address strobe is low, the read and write strobes are high, and the configuration-enable and ready outputs are low.
- R2: An accepted request produces the following sequence. The chip select goes low for the whole access. The address strobe is active for exactly one cycle while the address is driven. The read or write strobe is then active for STRB_CYC cycles. Req_ready pulses for one cycle in the cycle after the strobe ends, and the chip select is high again in that cycle.
- R3: A read samples bus_din on the last strobe cycle and presents the value on rsp_rdata together with the req_ready pulse.
- R4: A write drives its request data on bus_dout throughout the access, and only the write strobe toggles.
- R5: Register bit 2 sets the write strobe polarity, bit 3 the read strobe polarity and bit 4 the address strobe polarity. A bit at 0 makes that strobe active-low and a bit at 1 makes it active-high. When the bus is idle or stalled, each strobe rests at the inverse of its active level.
- R6: With bit 0 set, a write request waits while fifo_full is high. While it waits, the chip select stays high and req_ready stays low. The write starts once fifo_full drops. With bit 0 clear, or for a read, fifo_full has no effect.
- R7: With bit 1 set, a read request waits while fifo_empty is high, with the same idle bus and low req_ready as in R6. With bit 1 clear, or for a write, fifo_empty has no effect.
- R8: Writing 1 to bit 5 makes the next bus access a configuration write. This access uses address 0 and drives register bits [31:16] on bus_dout. It asserts bus_cfg_en for the whole access, takes priority over any waiting request, ignores the FIFO flags and gives no req_ready pulse.
- R9: Bit 5 reads back as 1 from the write that sets it until the configuration access completes, and as 0 from then on. While bit 5 is 1, writes to bit 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data for the control register |
| reg_rdata | output | 32 | Read-back of the control register |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ready | output | 1 | One-cycle pulse when the request completes |
| rsp_rdata | output | DW | Read data, valid with req_ready |
| fifo_full | input | 1 | External FIFO full flag |
| fifo_empty | input | 1 | External FIFO empty flag |
| bus_din | input | DW | Data from the external bus |
| bus_addr | output | AW | Address to the external bus |
| bus_dout | output | DW | Data to the external bus |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_ale | output | 1 | Address strobe, polarity per bit 4 |
| bus_rd | output | 1 | Read strobe, polarity per bit 3 |
| bus_wr | output | 1 | Write strobe, polarity per bit 2 |
| bus_cfg_en | output | 1 | Configuration-enable for the RAM configuration write |

## Verification
The hardest case to reach is a configuration command that meets a waiting request in the same cycle. It also has to carry a write to the command bit during the configuration access. The bench first parks a read behind the empty flag and issues the command. It then releases the flag so that both become eligible together, and rewrites bit 5 to 0 while the address strobe is active. It then checks that the configuration write goes first, that bit 5 stays at 1 until completion, and that the parked read follows. Before that, all eight polarity combinations are swept with a write and a read each, and every pairing of enable and flag is run.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int REG_W  = 32;
    localparam int CFG_W  = 16;
    localparam int B_FEN  = 0;
    localparam int B_EEN  = 1;
    localparam int B_WPOL = 2;
    localparam int B_RPOL = 3;
    localparam int B_APOL = 4;
    localparam int B_GO   = 5;
    localparam int B_CFG  = 16;

    typedef struct packed {
        logic             full_en;
        logic             empty_en;
        logic             wr_pol;
        logic             rd_pol;
        logic             ale_pol;
        logic             cfg_go;
        logic [CFG_W-1:0] cfg_word;
    } ctrl_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_STRB, ST_DONE} seq_st_e;
endpackage

// File: rtl/hbus_regs.sv
module hbus_regs
    import hbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             cfg_done,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] reg_rdata
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr) begin
            ctrl_d.full_en  = reg_wdata[B_FEN];
            ctrl_d.empty_en = reg_wdata[B_EEN];
            ctrl_d.wr_pol   = reg_wdata[B_WPOL];
            ctrl_d.rd_pol   = reg_wdata[B_RPOL];
            ctrl_d.ale_pol  = reg_wdata[B_APOL];
            ctrl_d.cfg_word = reg_wdata[B_CFG +: CFG_W];
            if (!ctrl_q.cfg_go) begin
                ctrl_d.cfg_go = reg_wdata[B_GO];
            end
        end
        if (cfg_done) begin
            ctrl_d.cfg_go = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q         <= '0;
            ctrl_q.ale_pol <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[B_FEN]            = ctrl_q.full_en;
        reg_rdata[B_EEN]            = ctrl_q.empty_en;
        reg_rdata[B_WPOL]           = ctrl_q.wr_pol;
        reg_rdata[B_RPOL]           = ctrl_q.rd_pol;
        reg_rdata[B_APOL]           = ctrl_q.ale_pol;
        reg_rdata[B_GO]             = ctrl_q.cfg_go;
        reg_rdata[B_CFG +: CFG_W]   = ctrl_q.cfg_word;
    end

    assign ctrl = ctrl_q;

    assert_go_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cfg_go && !cfg_done) |=> ctrl_q.cfg_go);
    assert_go_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !ctrl_q.cfg_go);
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int STRB_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] rsp_rdata,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_cs_n,
    output logic          bus_cfg_en,
    output logic          ale_act,
    output logic          rd_act,
    output logic          wr_act,
    output logic          cfg_done
);
    localparam int CW = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRB_CYC - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          wr;
        logic          cfg;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic stall;

    assign stall = req_write ? (ctrl.full_en && fifo_full)
                             : (ctrl.empty_en && fifo_empty);

    always_comb begin
        s_d      = s_q;
        cfg_done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (ctrl.cfg_go) begin
                    s_d.st    = ST_ALE;
                    s_d.wr    = 1'b1;
                    s_d.cfg   = 1'b1;
                    s_d.addr  = '0;
                    s_d.wdata = DW'(ctrl.cfg_word);
                end else if (req_valid && !stall) begin
                    s_d.st    = ST_ALE;
                    s_d.wr    = req_write;
                    s_d.cfg   = 1'b0;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                end
            end
            ST_ALE: begin
                s_d.st  = ST_STRB;
                s_d.cnt = '0;
            end
            ST_STRB: begin
                if (s_q.cnt == LAST) begin
                    s_d.st = ST_DONE;
                    if (!s_q.wr) begin
                        s_d.rdata = bus_din;
                    end
                    cfg_done = s_q.cfg;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ale_act    = (s_q.st == ST_ALE);
    assign wr_act     = (s_q.st == ST_STRB) && s_q.wr;
    assign rd_act     = (s_q.st == ST_STRB) && !s_q.wr;
    assign bus_cs_n   = !((s_q.st == ST_ALE) || (s_q.st == ST_STRB));
    assign bus_cfg_en = s_q.cfg && !bus_cs_n;
    assign bus_addr   = s_q.addr;
    assign bus_dout   = s_q.wdata;
    assign req_ready  = (s_q.st == ST_DONE) && !s_q.cfg;
    assign rsp_rdata  = s_q.rdata;

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_act |=> (!ale_act && (rd_act || wr_act)));
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_IDLE) && !ctrl.cfg_go && req_valid && req_write &&
         ctrl.full_en && fifo_full) |=> bus_cs_n);
    assert_empty_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_IDLE) && !ctrl.cfg_go && req_valid && !req_write &&
         ctrl.empty_en && fifo_empty) |=> bus_cs_n);
    assert_cfg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_IDLE) && ctrl.cfg_go) |=> (ale_act && bus_cfg_en));
endmodule

// File: rtl/hbus_pol.sv
module hbus_pol #(
    parameter int N = 3
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] pol,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_strobe
        assign lvl[i] = act[i] ~^ pol[i];
    end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int STRB_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    rsp_rdata,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    bus_din,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_cs_n,
    output logic             bus_ale,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             bus_cfg_en
);
    ctrl_t ctrl;
    logic  cfg_done, ale_act, rd_act, wr_act;
    logic [2:0] lvl;

    hbus_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .cfg_done(cfg_done), .ctrl(ctrl), .reg_rdata(reg_rdata)
    );

    hbus_seq #(.AW(AW), .DW(DW), .STRB_CYC(STRB_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .bus_din(bus_din),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_cs_n(bus_cs_n),
        .bus_cfg_en(bus_cfg_en), .ale_act(ale_act), .rd_act(rd_act),
        .wr_act(wr_act), .cfg_done(cfg_done)
    );

    hbus_pol #(.N(3)) u_pol (
        .act({ale_act, rd_act, wr_act}),
        .pol({ctrl.ale_pol, ctrl.rd_pol, ctrl.wr_pol}),
        .lvl(lvl)
    );

    assign {bus_ale, bus_rd, bus_wr} = lvl;

    assert_cs_during_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |=> !bus_cs_n);
endmodule

// File: tb/hbus_ctrl_tb.sv
module hbus_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rsp_rdata;
    logic          fifo_full = 1'b0, fifo_empty = 1'b0;
    logic [DW-1:0] bus_din;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_cs_n, bus_ale, bus_rd, bus_wr, bus_cfg_en;

    int vecs = 0;
    int fails = 0;
    bit pw = 0, pr = 0, pa = 1;

    always #4 clk = ~clk;

    assign bus_din = bus_addr ^ 16'hC35A;

    hbus_ctrl #(.AW(AW), .DW(DW), .STRB_CYC(SC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_cfg_en(bus_cfg_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input bit cs_on, input bit a_on,
                            input bit r_on, input bit w_on);
        chk({tag, " cs_n"}, 32'(bus_cs_n), 32'(!cs_on));
        chk({tag, " ale"},  32'(bus_ale),  32'(a_on ? pa : !pa));
        chk({tag, " rd"},   32'(bus_rd),   32'(r_on ? pr : !pr));
        chk({tag, " wr"},   32'(bus_wr),   32'(w_on ? pw : !pw));
    endtask

    function automatic logic [31:0] regval(input logic [15:0] cw, input bit go,
                                           input bit ee, input bit fe);
        return {cw, 10'b0, go, pa, pr, pw, ee, fe};
    endfunction

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input int stall_n, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        for (int i = 0; i < stall_n; i++) begin
            @(negedge clk);
            chk_pins({tag, " held"}, 0, 0, 0, 0);
            chk({tag, " held ready"}, 32'(req_ready), 0);
        end
        if (stall_n > 0) begin
            fifo_full = 1'b0; fifo_empty = 1'b0;
        end
        @(negedge clk);
        chk_pins({tag, " R2 addr phase"}, 1, 1, 0, 0);
        chk({tag, " R2 addr"}, 32'(bus_addr), 32'(a));
        chk({tag, " cfg_en"}, 32'(bus_cfg_en), 0);
        for (int i = 0; i < SC; i++) begin
            @(negedge clk);
            chk_pins({tag, " R2 strobe phase"}, 1, 0, !wr, wr);
            chk({tag, " R2 ready low"}, 32'(req_ready), 0);
            if (wr) chk({tag, " R4 dout"}, 32'(bus_dout), 32'(d));
        end
        @(negedge clk);
        chk({tag, " R2 ready"}, 32'(req_ready), 1);
        chk_pins({tag, " R2 end"}, 0, 0, 0, 0);
        if (!wr) chk({tag, " R3 rdata"}, 32'(rsp_rdata), 32'(a ^ 16'hC35A));
        req_valid = 1'b0;
        @(negedge clk);
        chk({tag, " R2 ready pulse"}, 32'(req_ready), 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reg reset", reg_rdata, 32'h0000_0010);
        chk_pins("R1 idle", 0, 0, 0, 0);
        chk("R1 cfg_en", 32'(bus_cfg_en), 0);
        chk("R1 ready", 32'(req_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 sweep of all polarity settings, one write and one read each
        for (int p = 0; p < 8; p++) begin
            pw = p[0]; pr = p[1]; pa = p[2];
            reg_write(regval(16'h0, 0, 0, 0));
            chk("R5 readback", reg_rdata, regval(16'h0, 0, 0, 0));
            chk_pins("R5 idle levels", 0, 0, 0, 0);
            access(1, 16'(16'h1100 + p * 16'h0101), 16'(16'h7E00 + p * 16'h0013), 0, "R5 R4 write");
            access(0, 16'(16'h2200 + p * 16'h0305), 16'h0, 0, "R5 R3 read");
        end

        pw = 0; pr = 1; pa = 0;
        // R6 full flag against writes and reads
        reg_write(regval(16'h0, 0, 0, 1));
        fifo_full = 1'b1;
        access(1, 16'h3001, 16'hBEEF, 4, "R6 write stalled");
        fifo_full = 1'b1;
        access(0, 16'h3002, 16'h0, 0, "R6 read ignores full");
        fifo_full = 1'b0;
        reg_write(regval(16'h0, 0, 0, 0));
        fifo_full = 1'b1;
        access(1, 16'h3003, 16'h1234, 0, "R6 write full disabled");
        fifo_full = 1'b0;

        // R7 empty flag against reads and writes
        reg_write(regval(16'h0, 0, 1, 0));
        fifo_empty = 1'b1;
        access(0, 16'h4001, 16'h0, 3, "R7 read stalled");
        fifo_empty = 1'b1;
        access(1, 16'h4002, 16'h5555, 0, "R7 write ignores empty");
        fifo_empty = 1'b0;
        reg_write(regval(16'h0, 0, 0, 0));
        fifo_empty = 1'b1;
        access(0, 16'h4003, 16'h0, 0, "R7 read empty disabled");
        fifo_empty = 1'b0;

        // R8/R9: configuration command racing a parked read
        reg_write(regval(16'h0, 0, 1, 0));
        fifo_empty = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0777;
        reg_wr = 1'b1; reg_wdata = regval(16'hA55A, 1, 1, 0);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9 go set", reg_rdata, regval(16'hA55A, 1, 1, 0));
        chk("R7 parked cs_n", 32'(bus_cs_n), 1);
        fifo_empty = 1'b0;
        @(negedge clk);
        chk_pins("R8 cfg addr phase", 1, 1, 0, 0);
        chk("R8 cfg_en", 32'(bus_cfg_en), 1);
        chk("R8 cfg addr", 32'(bus_addr), 0);
        reg_wr = 1'b1; reg_wdata = regval(16'hA55A, 0, 1, 0);
        for (int i = 0; i < SC; i++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            chk("R9 go ignores clear", 32'(reg_rdata[5]), 1);
            chk_pins("R8 cfg strobe", 1, 0, 0, 1);
            chk("R8 cfg dout", 32'(bus_dout), 32'h0000_A55A);
            chk("R8 cfg_en strobe", 32'(bus_cfg_en), 1);
            chk("R8 no ready", 32'(req_ready), 0);
        end
        @(negedge clk);
        chk("R9 go self-clear", 32'(reg_rdata[5]), 0);
        chk("R8 no ready after cfg", 32'(req_ready), 0);
        chk("R8 cfg_en off", 32'(bus_cfg_en), 0);
        @(negedge clk);
        chk_pins("R8 gap", 0, 0, 0, 0);
        @(negedge clk);
        chk_pins("R8 parked read addr phase", 1, 1, 0, 0);
        chk("R8 parked read addr", 32'(bus_addr), 32'h0777);
        chk("R8 parked read cfg_en", 32'(bus_cfg_en), 0);
        for (int i = 0; i < SC; i++) @(negedge clk);
        @(negedge clk);
        chk("R3 parked read ready", 32'(req_ready), 1);
        chk("R3 parked read data", 32'(rsp_rdata), 32'(16'h0777 ^ 16'hC35A));
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 go stays clear", 32'(reg_rdata[5]), 0);

        report();
    end
endmodule